// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps a 256K x 16 dynamic RAM alive. After reset it holds every strobe high for the power-up pause. It then runs a burst of wake-up refresh cycles and only afterwards reports that the memory is ready. From then on it schedules one CAS-before-RAS refresh per refresh interval, so that all 512 internal rows are visited within the retention period. The device's own row counter supplies the row, so no address is driven.

The strobe lines are shared with the access controller. Before each of its cycles the sequencer raises a bus request. It holds that request until a grant arrives, and it drives RAS and both CAS strobes only while granted. Refreshes that come due while the grant is withheld are counted and issued later, one cycle after another. If the backlog grows past its limit, retention can no longer be trusted. The block then raises a sticky error, withdraws the ready flag, drops the backlog and runs the wake-up burst again. The access controller is expected to keep host traffic off the bus while the ready flag is low.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset is released, for PWRUP_CYC = CLK_MHZ*PWRUP_US clock cycles (20000 by default) ras_n, lcas_n and ucas_n stay high, bus_req stays low and init_done stays low.
- R2: After the pause, exactly WAKE_CYCLES (8) refresh cycles are issued, and then init_done goes high. init_done stays low until the last of them has finished its precharge.
- R3: Every cycle is CAS-before-RAS. lcas_n and ucas_n always carry the same level. Both are low for at least T_CSR_CYC cycles before ras_n falls, stay low while ras_n is low, and are high again in the cycle in which ras_n rises.
- R4: ras_n stays low for exactly T_RAS_CYC cycles per refresh. It stays high for at least T_RP_CYC cycles between refreshes. Successive falling edges of ras_n are at least T_RC_CYC cycles apart.
- R5: Strobes are driven low only while bus_gnt is high. bus_req is low while nothing is owed. Once raised, it stays high until the grant arrives.
- R6: While init_done is high, one refresh becomes owed every REFI_CYC = CLK_MHZ*REFI_NS/1000 cycles (1560 by default), counted from the rise of init_done. With the grant always given, exactly one refresh cycle follows each such interval, starting within 20 cycles.
- R7: While the grant is withheld, owed refreshes accumulate up to PEND_MAX (8) without error. Once granted, all of them are issued, and bus_req goes low for at least one cycle between any two of them.
- R8: If a refresh comes due while PEND_MAX are already owed, ref_err goes high and stays high until reset. In the same cycle init_done goes low and the backlog is dropped. Exactly WAKE_CYCLES refresh cycles then follow, after which init_done goes high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_gnt | input | 1 | Strobe bus granted by the access controller; held for as long as bus_req is high once given |
| bus_req | output | 1 | Request for the strobe bus |
| ras_n | output | 1 | Row address strobe to the DRAM, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| init_done | output | 1 | Memory is initialised and is being kept refreshed |
| ref_err | output | 1 | Sticky flag: refresh backlog overflowed |

## Verification
A refresh cycle is due two clocks after bus_req rises when the grant is immediate: one clock to sample the grant, then T_CSR_CYC clocks of CAS lead before ras_n falls. The next one can follow no sooner than T_RAS_CYC plus the stretched precharge plus two idle/request clocks. The monitor therefore measures every pulse edge by edge on the falling clock edge, rather than at fixed instants. The interval-driven results, such as the first refresh after ready and the error on the ninth withheld interval, are sampled with a 100-cycle margin after the nominal due time and well before the next interval. Because intervals are 1560 cycles long, each sample has only one possible expected value.

// File: rtl/drs_pkg.sv
// Shared types for the DRAM refresh sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package drs_pkg;

    // Top-level life phase of the memory
    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_WAKE  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    // Steps of one CAS-before-RAS strobe cycle
    typedef enum logic [2:0] {
        CY_IDLE = 3'd0,
        CY_REQ  = 3'd1,
        CY_CSR  = 3'd2,
        CY_RASL = 3'd3,
        CY_PRE  = 3'd4
    } cyc_e;

endpackage

// File: rtl/drs_interval_timer.sv
// Free-running interval timer: emits a one-cycle tick every PERIOD cycles
// while enabled, and restarts from zero whenever it is disabled.
// Assumes PERIOD >= 2.
module drs_interval_timer #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    // Tick on the last count of each period
    assign tick = en && (cnt == LAST);

    // Advance the count, wrapping on tick and clearing when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/drs_backlog.sv
// Counts refreshes that are owed but not yet issued. Flags an overflow when a
// new one arrives while LIMIT are already owed and none completes that cycle.
// Assumes dec is only asserted while at least one refresh is owed.
module drs_backlog #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic owed,
    output logic ovf
);
    localparam int PW = $clog2(LIMIT + 1);
    localparam logic [PW-1:0] FULL = PW'(LIMIT);

    logic [PW-1:0] pend;

    assign owed = (pend != '0);
    assign ovf  = inc && !dec && (pend == FULL);

    // Track the owed count; clear on request, saturate on overflow
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend <= '0;
        end else if (inc && !dec && !ovf) begin
            pend <= pend + 1'b1;
        end else if (dec && !inc) begin
            pend <= pend - 1'b1;
        end
    end
endmodule

// File: rtl/drs_cycle_gen.sv
// Generates one CAS-before-RAS refresh cycle per request/grant handshake.
// It requests the bus while want is high, lowers CAS for T_CSR cycles, then
// RAS for T_RAS cycles, then holds all strobes high for T_PRE cycles before
// it hands the bus back. done pulses in the last precharge cycle.
// Assumes the grant stays high for as long as req is high once given.
module drs_cycle_gen
    import drs_pkg::*;
#(
    parameter int T_CSR = 1,
    parameter int T_RAS = 6,
    parameter int T_PRE = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic gnt,
    output logic req,
    output logic ras_n,
    output logic cas_n,
    output logic done
);
    localparam int MAXT = (T_RAS > T_PRE) ? ((T_RAS > T_CSR) ? T_RAS : T_CSR)
                                          : ((T_PRE > T_CSR) ? T_PRE : T_CSR);
    localparam int CW = $clog2(MAXT + 1);
    localparam logic [CW-1:0] CSR_LAST = CW'(T_CSR - 1);
    localparam logic [CW-1:0] RAS_LAST = CW'(T_RAS - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(T_PRE - 1);

    cyc_e          st;
    logic [CW-1:0] cnt;

    // Strobe levels decoded from the registered step
    assign req   = (st != CY_IDLE);
    assign ras_n = (st != CY_RASL);
    assign cas_n = !((st == CY_CSR) || (st == CY_RASL));
    assign done  = (st == CY_PRE) && (cnt == '0);

    // Step through request, CAS lead, RAS low and precharge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= CY_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                CY_IDLE: if (want) st <= CY_REQ;
                CY_REQ: if (gnt) begin
                    st  <= CY_CSR;
                    cnt <= CSR_LAST;
                end
                CY_CSR: if (cnt == '0) begin
                    st  <= CY_RASL;
                    cnt <= RAS_LAST;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                CY_RASL: if (cnt == '0) begin
                    st  <= CY_PRE;
                    cnt <= PRE_LAST;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                CY_PRE: if (cnt == '0) begin
                    st <= CY_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: st <= CY_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dram_refresh_seq.sv
// DRAM refresh and power-up sequencer (top).
// After reset: strobes held high for the power-up pause, then a burst of
// wake-up refresh cycles, then distributed CAS-before-RAS refresh at one per
// interval. A refresh backlog past PEND_MAX sets a sticky error and reruns
// the wake-up burst. Assumes the access controller holds bus_gnt while
// bus_req is high once granted, and keeps host traffic off while
// init_done is low.
module dram_refresh_seq
    import drs_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int PWRUP_US    = 200,
    parameter int REFI_NS     = 15600,
    parameter int WAKE_CYCLES = 8,
    parameter int PEND_MAX    = 8,
    parameter int T_CSR_CYC   = 1,
    parameter int T_RAS_CYC   = 6,
    parameter int T_RP_CYC    = 4,
    parameter int T_RC_CYC    = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_gnt,
    output logic bus_req,
    output logic ras_n,
    output logic lcas_n,
    output logic ucas_n,
    output logic init_done,
    output logic ref_err
);
    localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
    localparam int REFI_CYC  = (CLK_MHZ * REFI_NS) / 1000;
    localparam int PRE_CYC   = ((T_RC_CYC - T_RAS_CYC) > T_RP_CYC)
                               ? (T_RC_CYC - T_RAS_CYC) : T_RP_CYC;
    localparam int PCW = $clog2(PWRUP_CYC + 1);
    localparam int WCW = $clog2(WAKE_CYCLES + 1);
    localparam logic [PCW-1:0] PAUSE_LAST = PCW'(PWRUP_CYC - 1);
    localparam logic [WCW-1:0] WAKE_INIT  = WCW'(WAKE_CYCLES);
    localparam logic [WCW-1:0] WAKE_ONE   = WCW'(1);

    phase_e         phase;
    logic [PCW-1:0] pause_cnt;
    logic [WCW-1:0] wake_left;
    logic           err_q;
    logic           tick, owed, ovf, done, want, cas_n;

    // Work wanted: outstanding wake cycles, or owed refreshes in service
    assign want = ((phase == PH_WAKE) && (wake_left != '0)) ||
                  ((phase == PH_RUN) && owed);

    drs_interval_timer #(.PERIOD(REFI_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (phase == PH_RUN),
        .tick (tick)
    );

    drs_backlog #(.LIMIT(PEND_MAX)) u_backlog (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (phase != PH_RUN),
        .inc  (tick),
        .dec  (done && (phase == PH_RUN)),
        .owed (owed),
        .ovf  (ovf)
    );

    drs_cycle_gen #(
        .T_CSR(T_CSR_CYC),
        .T_RAS(T_RAS_CYC),
        .T_PRE(PRE_CYC)
    ) u_cycle (
        .clk  (clk),
        .rst_n(rst_n),
        .want (want),
        .gnt  (bus_gnt),
        .req  (bus_req),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .done (done)
    );

    assign lcas_n    = cas_n;
    assign ucas_n    = cas_n;
    assign init_done = (phase == PH_RUN);
    assign ref_err   = err_q;

    // Phase sequencing: pause, wake burst, run; overflow returns to wake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_PAUSE;
        end else begin
            case (phase)
                PH_PAUSE: if (pause_cnt == PAUSE_LAST) phase <= PH_WAKE;
                PH_WAKE:  if (done && (wake_left == WAKE_ONE)) phase <= PH_RUN;
                PH_RUN:   if (ovf) phase <= PH_WAKE;
                default:  phase <= PH_PAUSE;
            endcase
        end
    end

    // Count out the power-up pause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_cnt <= '0;
        end else if ((phase == PH_PAUSE) && (pause_cnt != PAUSE_LAST)) begin
            pause_cnt <= pause_cnt + 1'b1;
        end
    end

    // Count remaining wake-up cycles; reload for a later rerun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_left <= WAKE_INIT;
        end else if ((phase == PH_WAKE) && done) begin
            wake_left <= (wake_left == WAKE_ONE) ? WAKE_INIT : wake_left - 1'b1;
        end
    end

    // Sticky backlog-overflow flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (ovf) begin
            err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
// Assertion checker for dram_refresh_seq, attached by bind below.
// Assumes the same timing parameters as the bound instance.
module dram_refresh_seq_chk #(
    parameter int CLK_MHZ   = 100,
    parameter int PWRUP_US  = 200,
    parameter int T_RAS_CYC = 6,
    parameter int T_RP_CYC  = 4
) (
    input logic clk,
    input logic rst_n,
    input logic bus_gnt,
    input logic bus_req,
    input logic ras_n,
    input logic lcas_n,
    input logic ucas_n,
    input logic init_done,
    input logic ref_err
);
    localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;

    int boot_cnt;
    int low_len;
    int high_len;

    // Cycles since reset release, saturating at the pause length
    always_ff @(posedge clk) begin
        if (!rst_n) boot_cnt <= 0;
        else if (boot_cnt < PWRUP_CYC) boot_cnt <= boot_cnt + 1;
    end

    // Lengths of the current RAS low and high runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_len  <= 0;
            high_len <= 0;
        end else if (!ras_n) begin
            low_len  <= low_len + 1;
            high_len <= 0;
        end else begin
            low_len  <= 0;
            if (high_len < 1000) high_len <= high_len + 1;
        end
    end

    p_pause_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_cnt < PWRUP_CYC) |-> (ras_n && lcas_n && ucas_n && !bus_req && !init_done));

    p_cbr_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!lcas_n && !ucas_n));

    p_cas_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lcas_n == ucas_n);

    p_ras_under_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !lcas_n);

    p_ras_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_len == T_RAS_CYC));

    p_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (high_len >= T_RP_CYC));

    p_strobe_needs_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !lcas_n) |-> bus_gnt);

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_err |=> ref_err);

    p_err_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_err) |-> !init_done);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
    .CLK_MHZ  (CLK_MHZ),
    .PWRUP_US (PWRUP_US),
    .T_RAS_CYC(T_RAS_CYC),
    .T_RP_CYC (T_RP_CYC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_gnt  (bus_gnt),
    .bus_req  (bus_req),
    .ras_n    (ras_n),
    .lcas_n   (lcas_n),
    .ucas_n   (ucas_n),
    .init_done(init_done),
    .ref_err  (ref_err)
);

// File: tb/dram_refresh_seq_tb_top.sv
// Scoreboard bench: a driver task queues the expected RAS pulse widths and a
// negedge monitor pops one per observed refresh cycle and checks its timing.
module dram_refresh_seq_tb_top;
    localparam int PWRUP = 20000;
    localparam int REFI  = 1560;
    localparam int TCSR  = 1;
    localparam int TRAS  = 6;
    localparam int TRP   = 4;
    localparam int TRC   = 11;
    localparam int WDOG  = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt_en = 1'b1;
    logic bus_gnt, bus_req, ras_n, lcas_n, ucas_n, init_done, ref_err;

    assign bus_gnt = bus_req & gnt_en;

    always #5 clk = ~clk;

    dram_refresh_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
        .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .init_done(init_done), .ref_err(ref_err)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int exp_q[$];
    int fall_t[$];
    int n_falls = 0, req_drops = 0, req_falls = 0;
    int cur_w = 0, lead = 0, low_len = 0, high_len = 0, last_fall = 0;
    logic prev_ras = 1'b1, prev_req = 1'b0;
    bit finished = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Driver: queue n expected refresh pulses of nominal width
    task automatic expect_refresh(input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(TRAS);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic wait_init(input logic lvl);
        while (init_done !== lvl) @(negedge clk);
    endtask

    always @(posedge clk) cyc++;

    // Monitor: measure every strobe cycle and compare with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                n_falls++;
                fall_t.push_back(cyc);
                check(lead >= TCSR, "R3", "CAS lead before RAS fall", lead, TCSR);
                check(lcas_n == ucas_n, "R3", "CAS pair equal at fall", lcas_n, ucas_n);
                check(bus_gnt == 1'b1, "R5", "grant during strobe", bus_gnt, 1);
                if (n_falls > 1) begin
                    check(high_len >= TRP, "R4", "RAS precharge", high_len, TRP);
                    check(cyc - last_fall >= TRC, "R4", "RAS cycle time", cyc - last_fall, TRC);
                end
                last_fall = cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected refresh cycle", n_falls, 0);
                    cur_w = TRAS;
                end else begin
                    cur_w = exp_q.pop_front();
                end
            end
            if (!prev_ras && ras_n) begin
                check(low_len == cur_w, "R4", "RAS low width", low_len, cur_w);
                check(lcas_n && ucas_n, "R3", "CAS released with RAS", lcas_n, 1);
            end
            if (!ras_n) begin low_len++; high_len = 0; end
            else begin low_len = 0; high_len++; end
            if (!lcas_n && ras_n) lead++;
            else if (lcas_n) lead = 0;
            if (prev_req && !bus_req) begin
                req_falls++;
                if (!gnt_en) req_drops++;
            end
            prev_ras = ras_n;
            prev_req = bus_req;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        if (cyc > WDOG && !finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int rel, t0, f0, rf;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        rel = cyc;
        expect_refresh(8);

        // R1: reset state and quiet pause
        repeat (10) @(negedge clk);
        check(ras_n && lcas_n && ucas_n, "R1", "strobes high after reset", ras_n, 1);
        check(!bus_req, "R1", "no request in pause", bus_req, 0);
        check(!init_done && !ref_err, "R1", "flags low after reset", init_done, 0);
        wait_until(rel + PWRUP - 20);
        check(n_falls == 0, "R1", "no RAS in pause", n_falls, 0);
        check(!bus_req && !init_done, "R1", "late pause quiet", bus_req, 0);

        // R2: wake burst then ready
        wait_init(1'b1);
        t0 = cyc;
        check(n_falls == 8, "R2", "wake cycles before ready", n_falls, 8);
        check(fall_t[0] - rel >= PWRUP, "R1", "first RAS after pause", fall_t[0] - rel, PWRUP);
        check(exp_q.size() == 0, "R2", "wake queue drained", exp_q.size(), 0);

        // R5/R6: idle between intervals, then one refresh per interval
        wait_until(t0 + REFI / 2);
        check(!bus_req, "R5", "no request while nothing owed", bus_req, 0);
        expect_refresh(3);
        wait_until(t0 + 3 * REFI + 100);
        check(exp_q.size() == 0, "R6", "periodic refreshes issued", exp_q.size(), 0);
        check(n_falls == 11, "R6", "refresh count", n_falls, 11);
        check((fall_t[8] - t0 >= REFI) && (fall_t[8] - t0 <= REFI + 20), "R6",
              "first interval refresh time", fall_t[8] - t0, REFI);

        // R7: backlog of three while grant withheld, drained on grant
        gnt_en = 1'b0;
        wait_until(t0 + 6 * REFI + 100);
        check(bus_req, "R5", "request held without grant", bus_req, 1);
        check(n_falls == 11 && ras_n, "R5", "no strobe without grant", n_falls, 11);
        check(req_drops == 0, "R5", "request never dropped", req_drops, 0);
        rf = req_falls;
        f0 = n_falls;
        expect_refresh(3);
        gnt_en = 1'b1;
        repeat (100) @(negedge clk);
        check(exp_q.size() == 0 && n_falls == f0 + 3, "R7", "backlog drained", n_falls - f0, 3);
        check(req_falls - rf == 3, "R7", "request gaps between cycles", req_falls - rf, 3);
        check(!ref_err, "R7", "no error within limit", ref_err, 0);

        // R8: overflow on the ninth withheld interval
        gnt_en = 1'b0;
        wait_until(t0 + 14 * REFI + 100);
        check(!ref_err && init_done, "R7", "eight owed without error", ref_err, 0);
        check(bus_req, "R5", "request still held", bus_req, 1);
        wait_until(t0 + 15 * REFI + 100);
        check(ref_err, "R8", "error on overflow", ref_err, 1);
        check(!init_done, "R8", "ready withdrawn", init_done, 0);
        check(req_drops == 0 && n_falls == f0 + 3, "R5", "no strobes while withheld", n_falls - f0, 3);
        expect_refresh(8);
        gnt_en = 1'b1;
        wait_init(1'b1);
        check(exp_q.size() == 0 && n_falls == f0 + 11, "R8", "wake burst rerun", n_falls - f0, 11);
        check(ref_err, "R8", "error sticky after rewake", ref_err, 1);

        // R6: periodic service resumes, error stays
        t0 = cyc;
        expect_refresh(1);
        wait_until(t0 + REFI + 100);
        check(exp_q.size() == 0 && n_falls == f0 + 12, "R6", "refresh after rewake", n_falls - f0, 12);
        check(ref_err, "R8", "error still sticky", ref_err, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule